// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block answers reads on a memory-mapped window by running a complete read sequence on an external serial flash. A 32-bit setup word defines how each sequence is framed: the opcode sent first, how many address bytes follow, how many dummy clocks come after the address, and whether the data comes back on one line or four. An ownership input says whether this engine may use the flash pins at all. When it is clear, the pins belong to a separate command-driven engine.

A read comes in on a valid/ready request port with its byte address. While it is in flight the engine drops chip select and sends the opcode and the address on line 0, most significant bit first. It then idles through the dummy clocks and shifts in the data. Chip select is released as soon as the response is presented. Each read returns `DATA_BYTES` consecutive bytes starting at the request address. The flash clock idles low, and every flash clock takes two system cycles: a low half and then a high half. The data lines are sampled at the end of the high half.

Back-pressure rules: `req_ready` is high only when no read is in flight and no response is waiting. A request is taken on a cycle with both `req_valid` and `req_ready` high. The response stays valid, with its data and error flag unchanged, until a cycle with `rsp_ready` high. Only one read is outstanding at a time.

Top module: `mmfr_engine`

## Requirements
- R1: `req_ready` is 1 exactly when the engine is idle (no read in flight, no response pending). A response keeps `rsp_valid`, `rsp_data` and `rsp_err` unchanged until it is taken with `rsp_ready`. The reset state is `req_ready`=1, `flash_cs_n`=1, `flash_sclk`=0, `rsp_valid`=0.
- R2: Flash clock mode 0. `flash_sclk` is 0 whenever `flash_cs_n` is 1. For an owned read of N flash clocks, `flash_cs_n` is 0 from the cycle after acceptance for exactly 2N cycles. During that time `flash_sclk` is 0 in even cycles and 1 in odd cycles. `rsp_valid` rises in the cycle after the last high half.
- R3: The opcode is setup bits 7:0. It is sent first on `flash_io_out[0]`, MSB first, one bit per flash clock, and is valid during the high half.
- R4: The number of address bytes is setup bits 9:8 plus one, so the encoded value 2 gives three bytes. The low-order bytes of `req_addr` are sent right after the opcode, MSB first.
- R5: The number of dummy clocks is 8 × setup bits 11:10 plus setup bits 28:24. `flash_io_oe` is 4'b0001 during the opcode and address clocks, and 4'b0000 during the dummy and data clocks and whenever chip select is high.
- R6: When setup bits 13:12 are not 3, the data phase takes 8×`DATA_BYTES` clocks and samples only `flash_io_in[1]`. Lines 0, 2 and 3 are ignored.
- R7: When setup bits 13:12 equal 3, the data phase takes 2×`DATA_BYTES` clocks. Each clock samples one nibble from `flash_io_in[3:0]`, with line 3 as the nibble MSB and the high nibble of each byte first.
- R8: The first byte received lands in `rsp_data[7:0]`, the next in `rsp_data[15:8]`, and so on. Within each byte the first bit received is the MSB.
- R9: A request accepted while `map_own` is 0 gives `rsp_valid`=1 with `rsp_err`=1 and `rsp_data`=0 in the next cycle. Chip select stays high and the flash clock does not toggle.
- R10: The setup word, `map_own` and `req_addr` are sampled only at acceptance. Changing them while a read is in flight does not change that read. Setup bits 15:14, 23:16 (write opcode) and 31:29 have no effect.
- R11: An owned read completes with `rsp_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_word | input | 32 | Read framing word (opcode, address bytes, dummy, lane mode) |
| map_own | input | 1 | 1: flash pins owned by this engine |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Engine can take a request |
| req_addr | input | ADDR_W | Byte address of the read |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8×DATA_BYTES | Read data, first byte in the low lane |
| rsp_err | output | 1 | Read refused because the pins were not owned |
| flash_sclk | output | 1 | Flash serial clock |
| flash_cs_n | output | 1 | Flash chip select, active low |
| flash_io_out | output | 4 | Values driven on the flash data lines |
| flash_io_oe | output | 4 | Per-line output enable |
| flash_io_in | input | 4 | Values sampled from the flash data lines |

## Verification
Some properties are checked by assertions on every cycle:
- the flash clock stays low while chip select is high, and alternates once chip select is low;
- no line is driven outside a frame;
- the idle handshake state is consistent;
- a pending response stays stable under back-pressure;
- an unowned request never lowers chip select.

The exact frame contents need the bench's scenarios: the opcode and address bit order, the dummy count built from both setup fields, single versus quad sampling with noise on the unused lines, byte packing, and isolation from setup and ownership changes during a read. These are checked against a behavioural flash model and a per-cycle reference.

// File: rtl/mmfr_pkg.sv
package mmfr_pkg;
  localparam int SETUP_W        = 32;
  localparam int MAX_ADDR_BYTES = 4;
  localparam int DMY_W          = 6;   // 8*3 + 31 = 55 fits

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_RESP  = 2'd2
  } mmfr_state_e;

  typedef enum logic [1:0] {
    PH_OPC = 2'd0,
    PH_ADR = 2'd1,
    PH_DMY = 2'd2,
    PH_DAT = 2'd3
  } mmfr_phase_e;

  typedef struct packed {
    logic [7:0]       opcode;
    logic [2:0]       adr_bytes;  // 1..4
    logic [DMY_W-1:0] dmy_clks;
    logic             quad;
  } mmfr_frame_t;
endpackage

// File: rtl/mmfr_setup_dec.sv
module mmfr_setup_dec
  import mmfr_pkg::*;
(
  input  logic [SETUP_W-1:0] setup,
  output mmfr_frame_t        frame
);
  // Fields with no effect on a read sequence.
  logic unused_setup_bits;
  assign unused_setup_bits = ^{setup[31:29], setup[23:14]};

  always_comb begin
    frame.opcode    = setup[7:0];
    frame.adr_bytes = {1'b0, setup[9:8]} + 3'd1;
    frame.dmy_clks  = {1'b0, setup[11:10], 3'b000} + {1'b0, setup[28:24]};
    frame.quad      = (setup[13:12] == 2'b11);
  end
endmodule

// File: rtl/mmfr_seq.sv
module mmfr_seq
  import mmfr_pkg::*;
#(
  parameter int DATA_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [2:0]       adr_bytes,
  input  logic [DMY_W-1:0] dmy_clks,
  input  logic             quad,
  output logic             busy,
  output logic             sclk,
  output logic             tick,
  output logic             last,
  output mmfr_phase_e      phase
);
  localparam int DAT_CLKS_1 = 8 * DATA_BYTES;
  localparam int DAT_CLKS_4 = 2 * DATA_BYTES;
  localparam int MAX_CLKS   = 8 + 8 * MAX_ADDR_BYTES + 55 + DAT_CLKS_1;
  localparam int CNT_W      = $clog2(MAX_CLKS + 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] adr_end;
  logic [CNT_W-1:0] dmy_end;
  logic [CNT_W-1:0] total;

  always_comb begin
    adr_end = CNT_W'(8) + CNT_W'({adr_bytes, 3'b000});
    dmy_end = adr_end + CNT_W'(dmy_clks);
    total   = dmy_end + (quad ? CNT_W'(DAT_CLKS_4) : CNT_W'(DAT_CLKS_1));
  end

  always_comb begin
    if (cnt < CNT_W'(8))   phase = PH_OPC;
    else if (cnt < adr_end) phase = PH_ADR;
    else if (cnt < dmy_end) phase = PH_DMY;
    else                    phase = PH_DAT;
  end

  assign tick = busy & sclk;
  assign last = tick && (cnt == total - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sclk <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      sclk <= 1'b0;
      cnt  <= '0;
    end else if (busy) begin
      if (!sclk) begin
        sclk <= 1'b1;
      end else begin
        sclk <= 1'b0;
        if (last) busy <= 1'b0;
        else      cnt  <= cnt + CNT_W'(1);
      end
    end
  end

  // R2: clock rests low outside a frame
  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  // R2: each high half is followed by a low half
  a_r2_alternate: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sclk) |=> !sclk);
endmodule

// File: rtl/mmfr_shift.sv
module mmfr_shift
  import mmfr_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [7:0]              load_op,
  input  logic [ADDR_W-1:0]       load_addr,
  input  logic [2:0]              load_adr_bytes,
  input  logic                    tick,
  input  mmfr_phase_e             phase,
  input  logic                    quad,
  input  logic [3:0]              io_in,
  output logic                    tx_bit,
  output logic [8*DATA_BYTES-1:0] rx_word
);
  localparam int AF_W = 8 * MAX_ADDR_BYTES;
  localparam int TX_W = 8 + AF_W;
  localparam int RX_W = 8 * DATA_BYTES;

  logic [TX_W-1:0] txsr;
  logic [RX_W-1:0] rxsr;
  logic [AF_W-1:0] adr_ext;
  logic [5:0]      pad;

  assign adr_ext = AF_W'(load_addr);
  assign pad     = {3'd4 - load_adr_bytes, 3'b000};
  assign tx_bit  = txsr[TX_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txsr <= '0;
      rxsr <= '0;
    end else if (load) begin
      txsr <= {load_op, adr_ext << pad};
    end else if (tick) begin
      txsr <= txsr << 1;
      if (phase == PH_DAT) begin
        if (quad) rxsr <= {rxsr[RX_W-5:0], io_in};
        else      rxsr <= {rxsr[RX_W-2:0], io_in[1]};
      end
    end
  end

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
    assign rx_word[8*g +: 8] = rxsr[RX_W-1-8*g -: 8];
  end
endmodule

// File: rtl/mmfr_engine.sv
module mmfr_engine
  import mmfr_pkg::*;
#(
  parameter  int ADDR_W     = 32,
  parameter  int DATA_BYTES = 4,
  localparam int DATA_W     = 8 * DATA_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SETUP_W-1:0] setup_word,
  input  logic               map_own,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rsp_err,
  output logic               flash_sclk,
  output logic               flash_cs_n,
  output logic [3:0]         flash_io_out,
  output logic [3:0]         flash_io_oe,
  input  logic [3:0]         flash_io_in
);
  mmfr_state_e      st;
  mmfr_frame_t      frame_d;
  logic [2:0]       adr_q;
  logic [DMY_W-1:0] dmy_q;
  logic             quad_q;
  logic             err_q;
  logic             start;
  logic             busy, tick, last, tx_bit;
  mmfr_phase_e      phase;
  logic [DATA_W-1:0] rx_word;

  mmfr_setup_dec u_dec (
    .setup (setup_word),
    .frame (frame_d)
  );

  assign req_ready = (st == ST_IDLE);
  assign start     = req_valid && req_ready && map_own;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      err_q  <= 1'b0;
      adr_q  <= 3'd1;
      dmy_q  <= '0;
      quad_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          if (map_own) begin
            st     <= ST_SHIFT;
            err_q  <= 1'b0;
            adr_q  <= frame_d.adr_bytes;
            dmy_q  <= frame_d.dmy_clks;
            quad_q <= frame_d.quad;
          end else begin
            st    <= ST_RESP;
            err_q <= 1'b1;
          end
        end
        ST_SHIFT: if (last) st <= ST_RESP;
        ST_RESP:  if (rsp_ready) st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  mmfr_seq #(.DATA_BYTES(DATA_BYTES)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .adr_bytes (adr_q),
    .dmy_clks  (dmy_q),
    .quad      (quad_q),
    .busy      (busy),
    .sclk      (flash_sclk),
    .tick      (tick),
    .last      (last),
    .phase     (phase)
  );

  mmfr_shift #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_shift (
    .clk            (clk),
    .rst_n          (rst_n),
    .load           (start),
    .load_op        (frame_d.opcode),
    .load_addr      (req_addr),
    .load_adr_bytes (frame_d.adr_bytes),
    .tick           (tick),
    .phase          (phase),
    .quad           (quad_q),
    .io_in          (flash_io_in),
    .tx_bit         (tx_bit),
    .rx_word        (rx_word)
  );

  assign flash_cs_n   = ~busy;
  assign flash_io_out = {3'b000, busy & tx_bit};
  assign flash_io_oe  = (busy && (phase == PH_OPC || phase == PH_ADR)) ? 4'b0001 : 4'b0000;
  assign rsp_valid    = (st == ST_RESP);
  assign rsp_err      = rsp_valid & err_q;
  assign rsp_data     = (rsp_valid && !err_q) ? rx_word : '0;

  // R1: idle handshake implies no frame and no pending response
  a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (flash_cs_n && !rsp_valid));
  // R1: a stalled response holds its contents
  a_r1_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));
  // R9: unowned request never reaches the pins
  a_r9_unowned_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !map_own) |=> (flash_cs_n && rsp_valid && rsp_err));
  // R5: lines undriven outside a frame
  a_r5_no_drive_idle: assert property (@(posedge clk) disable iff (!rst_n)
    flash_cs_n |-> (flash_io_oe == 4'b0000));
endmodule

// File: tb/sim_mmfr_engine.sv
module sim_mmfr_engine;
  localparam int CLK_PERIOD = 10;
  localparam int NB         = 4;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] setup_word = '0;
  logic        map_own = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_ready = 1'b1;
  logic [3:0]  io_in = '0;
  logic        req_ready, rsp_valid, rsp_err, sclk, cs_n;
  logic [31:0] rsp_data;
  logic [3:0]  io_out, io_oe;

  int n_cmp = 0;
  int n_bad = 0;

  mmfr_engine #(.ADDR_W(32), .DATA_BYTES(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .setup_word(setup_word), .map_own(map_own),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .flash_sclk(sclk), .flash_cs_n(cs_n), .flash_io_out(io_out), .flash_io_oe(io_oe),
    .flash_io_in(io_in)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  int m_busy = 0, m_rsp = 0, m_err = 0, m_cyc = 0, m_total = 0;
  int m_ab = 0, m_dmy = 0, m_quad = 0, m_acc = 0;
  logic [7:0]  m_op = '0;
  logic [31:0] m_addr = '0;

  function automatic logic [7:0] fmem(input logic [31:0] a);
    return 8'((a * 37) ^ (a >> 8) ^ 32'h5C);
  endfunction

  function automatic logic [31:0] exp_word(input logic [31:0] a);
    logic [31:0] w;
    for (int j = 0; j < NB; j++) w[8*j +: 8] = fmem(a + j);
    return w;
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_rsp = 0; m_err = 0;
    end else if (m_rsp != 0) begin
      if (rsp_ready) m_rsp = 0;
    end else if (m_busy != 0) begin
      m_cyc++;
      if (m_cyc == 2 * m_total) begin m_busy = 0; m_rsp = 1; end
    end else if (req_valid) begin
      m_acc++;
      if (map_own) begin
        m_busy  = 1; m_cyc = 0; m_err = 0;
        m_op    = setup_word[7:0];
        m_ab    = int'(setup_word[9:8]) + 1;
        m_dmy   = 8 * int'(setup_word[11:10]) + int'(setup_word[28:24]);
        m_quad  = (setup_word[13:12] == 2'b11) ? 1 : 0;
        m_total = 8 + 8 * m_ab + m_dmy + ((m_quad != 0) ? 2 * NB : 8 * NB);
        m_addr  = req_addr;
      end else begin
        m_rsp = 1; m_err = 1;
      end
    end
  end

  always @(negedge clk) begin
    int idx;
    int d;
    logic [7:0] b;
    logic [3:0] nz;
    logic       cbit;
    idx = m_cyc / 2;
    if (rst_n) begin
      check("R1 req_ready", {31'b0, req_ready}, {31'b0, (m_busy == 0 && m_rsp == 0)});
      check("R2 cs_n", {31'b0, cs_n}, {31'b0, m_busy == 0});
      check("R2 sclk", {31'b0, sclk}, {31'b0, (m_busy != 0 && m_cyc % 2 == 1)});
      check("R5 io_oe", {28'b0, io_oe}, (m_busy != 0 && idx < 8 + 8 * m_ab) ? 32'd1 : 32'd0);
      check("R9 rsp_valid", {31'b0, rsp_valid}, {31'b0, m_rsp != 0});
      if (m_rsp != 0) begin
        check("R9 R11 rsp_err", {31'b0, rsp_err}, {31'b0, m_err != 0});
        check((m_quad != 0) ? "R7 R8 quad data" : "R6 R8 single data",
              rsp_data, (m_err != 0) ? 32'd0 : exp_word(m_addr));
      end
      if (m_busy != 0 && m_cyc % 2 == 1 && idx < 8 + 8 * m_ab) begin
        if (idx < 8) cbit = m_op[7 - idx];
        else         cbit = m_addr[8 * m_ab - 1 - (idx - 8)];
        check((idx < 8) ? "R3 opcode bit" : "R4 address bit", {31'b0, io_out[0]}, {31'b0, cbit});
      end
    end
    // flash model: noise everywhere except the lanes carrying data
    nz = 4'($urandom);
    d = idx - (8 + 8 * m_ab + m_dmy);
    if (m_busy != 0 && d >= 0) begin
      if (m_quad != 0) begin
        b = fmem(m_addr + d / 2);
        nz = (d % 2 == 0) ? b[7:4] : b[3:0];
      end else begin
        b = fmem(m_addr + d / 8);
        nz[1] = b[7 - d % 8];
      end
    end
    io_in = nz;
  end

  task automatic do_read(input logic [31:0] sw, input logic own, input logic [31:0] a,
                         input int hold, input bit disturb);
    int acc0;
    acc0 = m_acc;
    @(negedge clk);
    setup_word = sw; map_own = own; req_addr = a; req_valid = 1'b1;
    rsp_ready = (hold == 0);
    while (m_acc == acc0) @(negedge clk);
    req_valid = 1'b0;
    if (disturb) begin setup_word = ~sw; map_own = ~own; req_addr = ~a; end
    while (m_rsp == 0) @(negedge clk);
    if (disturb) check("R10 latched framing", rsp_data, exp_word(a));
    repeat (hold) @(negedge clk);
    rsp_ready = 1'b1;
    while (m_rsp != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset req_ready", {31'b0, req_ready}, 32'd1);
    check("R2 reset cs_n", {31'b0, cs_n}, 32'd1);
    check("R2 reset sclk", {31'b0, sclk}, 32'd0);
    check("R1 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    do_read(32'h0002_0203, 1'b1, 32'h0012_3456, 0, 1'b0); // normal read, 3 addr bytes
    do_read(32'h0002_060B, 1'b1, 32'h00AB_CDEF, 0, 1'b0); // fast read, 8 dummy
    do_read(32'h0002_366B, 1'b1, 32'h0000_1000, 0, 1'b0); // quad data
    do_read(32'h0502_00A5, 1'b1, 32'h0000_77F1, 0, 1'b0); // 1 addr byte, 5 dummy bits
    do_read(32'h0355_FBEC, 1'b1, 32'hDEAD_BEEF, 0, 1'b0); // 4 addr bytes, quad, 19 dummy
    do_read(32'h0002_0203, 1'b0, 32'h0000_0040, 3, 1'b0); // R9 unowned, back-pressure
    do_read(32'h0002_060B, 1'b1, 32'h0000_2222, 5, 1'b1); // R10 disturb + R1 hold
    do_read(32'h0002_1203, 1'b1, 32'h0000_0300, 0, 1'b0); // lane mode 1 = single
    do_read(32'h00FF_2203, 1'b1, 32'h0000_0301, 2, 1'b0); // lane mode 2 = single, odd write op
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule